// File: doc/BRIEF.md
# Bus Initiator Address-Phase Controller

This block is the initiator side of a shared parallel bus whose control lines are active low. It takes one transaction request from local logic, then waits for a clock edge at which the bus is free and the grant is present. It then drives the command and address, asserts the cycle-framing line and watches the target-select line for a bounded number of clocks. If a target claims the cycle, the controller completes a single data transfer once the target is ready. If no target claims it, the controller performs a master abort. Either way it returns the bus to idle and reports the outcome.

On the local side the request uses a valid/ready handshake. A request is taken on an edge where `req_valid` and `req_ready` are both high, and command and address are captured at that edge. `req_ready` stays low from acceptance until the bus has been released, which is how local logic is held off. Status pins are plain levels. Each bus output has its own output-enable, so the pad logic can build tri-state drivers from them. Inputs are sampled from the resolved bus lines.

Top module: `busmst_addr_ctrl`

## Requirements
- R1: During and right after reset, every output enable (`frame_oe`, `irdy_oe`, `ad_oe`, `cbe_oe`) is low, `req_ready` is high, and `done`, `claimed` and `aborted` are low.
- R2: With a request pending, the controller starts only after an edge at which `frame_n_in`=1, `irdy_n_in`=1 and `gnt_n`=0 were all sampled together. In the cycle that follows that edge, `frame_oe`=1 and `frame_n_out`=0. While the bus is busy on either line, or while the grant is withheld, `frame_oe` stays 0.
- R3: `ad_oe` and `cbe_oe` are high for exactly the one address cycle, with `ad_out` equal to the captured address and `cbe_out` equal to the captured command. They are low at every other time.
- R4: From the cycle after the address cycle (clock 2), the controller drives `irdy_n_out`=0 with `irdy_oe`=1, and holds it until the transfer or the abort.
- R5: `devsel_n` is sampled at clock edges 2 through 5, counted from the qualifying edge as clock 0. A low value at any of these edges, including edge 5, claims the cycle: `claimed` rises and no abort occurs.
- R6: If `devsel_n` is high at every edge from 2 to 5, `frame_n_out` is driven 1 in the cycle after edge 5 while `irdy_n_out` stays 0. In the next cycle `irdy_n_out` is 1 and `done`=1 with `aborted`=1 and `claimed`=0.
- R7: Once the cycle is claimed, the transfer happens at the first edge with `trdy_n`=0. In the next cycle `frame_n_out`=1 and `irdy_n_out`=1, both still enabled, and `done`=1 for that one cycle only. In the cycle after that, all enables are low and `req_ready`=1.
- R8: Deasserting `gnt_n` after the transaction has started does not shorten or stop it.
- R9: `req_ready` is high only while no transaction is pending or in progress. `claimed` and `aborted` keep their value after `done` until the next accepted request, which clears both.
- R10: When `devsel_n` and `trdy_n` are both low at the same edge, the claim and the transfer take effect together, and completion follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Local request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_cmd | input | CMD_W | Bus command for the request |
| req_addr | input | ADDR_W | Bus address for the request |
| done | output | 1 | One-cycle pulse when the bus is released |
| claimed | output | 1 | Last transaction was claimed by a target |
| aborted | output | 1 | Last transaction ended in master abort |
| gnt_n | input | 1 | Bus grant, active low |
| frame_n_in | input | 1 | Resolved framing line |
| irdy_n_in | input | 1 | Resolved initiator-ready line |
| devsel_n | input | 1 | Target select, active low |
| trdy_n | input | 1 | Target ready, active low |
| frame_n_out | output | 1 | Framing line drive value |
| frame_oe | output | 1 | Framing line enable |
| irdy_n_out | output | 1 | Initiator-ready drive value |
| irdy_oe | output | 1 | Initiator-ready enable |
| ad_out | output | ADDR_W | Address drive value |
| ad_oe | output | 1 | Address enable |
| cbe_out | output | CMD_W | Command drive value |
| cbe_oe | output | 1 | Command enable |

## Verification
Two pairs of functions can land on the same edge. The first pair is a target claim arriving on edge 5 and the abort decision that edge 5 would otherwise make. The second pair is the claim and the data transfer arriving together on the first window edge. The vector table provokes both by placing `devsel_n` low exactly at edge 5, and by lowering `devsel_n` and `trdy_n` together at edge 2. The checks then judge that claim wins over abort (`claimed`=1, `aborted`=0, and `frame_n_out` held low after edge 5), and that completion appears exactly one cycle after the shared edge.

// File: rtl/busmst_pkg.sv
package busmst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ADDR,
    ST_RESP,
    ST_DATA,
    ST_ABRT,
    ST_FIN
  } mst_state_e;

  typedef struct packed {
    logic frame_n;
    logic frame_oe;
    logic irdy_n;
    logic irdy_oe;
    logic addr_oe;
  } pin_ctl_t;

  // Pin levels for each controller state.
  function automatic pin_ctl_t pins_for(mst_state_e s);
    pin_ctl_t p;
    p = '{frame_n: 1'b1, frame_oe: 1'b0, irdy_n: 1'b1, irdy_oe: 1'b0, addr_oe: 1'b0};
    case (s)
      ST_ADDR: p = '{frame_n: 1'b0, frame_oe: 1'b1, irdy_n: 1'b1, irdy_oe: 1'b1, addr_oe: 1'b1};
      ST_RESP,
      ST_DATA: p = '{frame_n: 1'b0, frame_oe: 1'b1, irdy_n: 1'b0, irdy_oe: 1'b1, addr_oe: 1'b0};
      ST_ABRT: p = '{frame_n: 1'b1, frame_oe: 1'b1, irdy_n: 1'b0, irdy_oe: 1'b1, addr_oe: 1'b0};
      ST_FIN:  p = '{frame_n: 1'b1, frame_oe: 1'b1, irdy_n: 1'b1, irdy_oe: 1'b1, addr_oe: 1'b0};
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/busmst_start_qual.sv
module busmst_start_qual (
  input  logic pending,
  input  logic gnt_n,
  input  logic frame_n_in,
  input  logic irdy_n_in,
  output logic start_ok
);
  logic bus_free;

  // The bus is free only with both framing and ready lines high.
  assign bus_free = frame_n_in & irdy_n_in;
  assign start_ok = pending & bus_free & ~gnt_n;
endmodule

// File: rtl/busmst_resp_window.sv
module busmst_resp_window #(
  parameter int FIRST_CLK = 2,
  parameter int LAST_CLK  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic window_last
);
  localparam int CNT_W = $clog2(LAST_CLK + 1);
  localparam logic [CNT_W-1:0] FIRST_V = CNT_W'(FIRST_CLK);
  localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(LAST_CLK);

  // Holds the index of the next clock edge while the window is open.
  logic [CNT_W-1:0] clk_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 clk_idx <= FIRST_V;
    else if (!run)              clk_idx <= FIRST_V;
    else if (clk_idx != LAST_V) clk_idx <= clk_idx + 1'b1;
  end

  assign window_last = run && (clk_idx == LAST_V);

  // R6: the owner must leave the window after its final edge
  a_r6_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
    window_last |=> !run);
endmodule

// File: rtl/busmst_pin_drv.sv
module busmst_pin_drv
  import busmst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4
) (
  input  mst_state_e        state,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [CMD_W-1:0]  cmd_q,
  output logic              frame_n_out,
  output logic              frame_oe,
  output logic              irdy_n_out,
  output logic              irdy_oe,
  output logic [ADDR_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [CMD_W-1:0]  cbe_out,
  output logic              cbe_oe
);
  pin_ctl_t ctl;

  assign ctl         = pins_for(state);
  assign frame_n_out = ctl.frame_n;
  assign frame_oe    = ctl.frame_oe;
  assign irdy_n_out  = ctl.irdy_n;
  assign irdy_oe     = ctl.irdy_oe;
  assign ad_oe       = ctl.addr_oe;
  assign cbe_oe      = ctl.addr_oe;
  assign ad_out      = ctl.addr_oe ? addr_q : '0;
  assign cbe_out     = ctl.addr_oe ? cmd_q  : '0;
endmodule

// File: rtl/busmst_addr_ctrl.sv
module busmst_addr_ctrl
  import busmst_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CMD_W     = 4,
  parameter int LAST_RESP = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              done,
  output logic              claimed,
  output logic              aborted,
  input  logic              gnt_n,
  input  logic              frame_n_in,
  input  logic              irdy_n_in,
  input  logic              devsel_n,
  input  logic              trdy_n,
  output logic              frame_n_out,
  output logic              frame_oe,
  output logic              irdy_n_out,
  output logic              irdy_oe,
  output logic [ADDR_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [CMD_W-1:0]  cbe_out,
  output logic              cbe_oe
);
  localparam int FIRST_RESP = 2;

  mst_state_e        state, state_nx;
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              claimed_q, aborted_q;
  logic              start_ok, win_last, accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  busmst_start_qual u_qual (
    .pending    (state == ST_WAIT),
    .gnt_n      (gnt_n),
    .frame_n_in (frame_n_in),
    .irdy_n_in  (irdy_n_in),
    .start_ok   (start_ok)
  );

  busmst_resp_window #(
    .FIRST_CLK (FIRST_RESP),
    .LAST_CLK  (LAST_RESP)
  ) u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (state == ST_RESP),
    .window_last (win_last)
  );

  // Claim takes priority over the abort decision on the final window edge.
  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (req_valid) state_nx = ST_WAIT;
      ST_WAIT: if (start_ok)  state_nx = ST_ADDR;
      ST_ADDR: state_nx = ST_RESP;
      ST_RESP: begin
        if (!devsel_n)     state_nx = trdy_n ? ST_DATA : ST_FIN;
        else if (win_last) state_nx = ST_ABRT;
      end
      ST_DATA: if (!trdy_n) state_nx = ST_FIN;
      ST_ABRT: state_nx = ST_FIN;
      ST_FIN:  state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      cmd_q     <= '0;
      claimed_q <= 1'b0;
      aborted_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept) begin
        addr_q    <= req_addr;
        cmd_q     <= req_cmd;
        claimed_q <= 1'b0;
        aborted_q <= 1'b0;
      end
      if (state == ST_RESP && !devsel_n) claimed_q <= 1'b1;
      if (state == ST_ABRT)              aborted_q <= 1'b1;
    end
  end

  assign done    = (state == ST_FIN);
  assign claimed = claimed_q;
  assign aborted = aborted_q;

  busmst_pin_drv #(
    .ADDR_W (ADDR_W),
    .CMD_W  (CMD_W)
  ) u_drv (
    .state       (state),
    .addr_q      (addr_q),
    .cmd_q       (cmd_q),
    .frame_n_out (frame_n_out),
    .frame_oe    (frame_oe),
    .irdy_n_out  (irdy_n_out),
    .irdy_oe     (irdy_oe),
    .ad_out      (ad_out),
    .ad_oe       (ad_oe),
    .cbe_out     (cbe_out),
    .cbe_oe      (cbe_oe)
  );

  // R2: a fresh framing assertion needs idle bus and grant on the prior edge
  a_r2_frame_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_oe && !frame_n_out && !$past(frame_oe))
      |-> $past(!gnt_n && frame_n_in && irdy_n_in));

  // R3: address and command appear only in the address cycle
  a_r3_ad_in_addr_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe || cbe_oe) |-> (frame_oe && !frame_n_out && irdy_n_out));

  // R6: ready line is released one cycle after the framing line
  a_r6_irdy_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_oe && frame_n_out && !irdy_n_out) |=> (irdy_oe && irdy_n_out && done));

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a lost grant never drops an owned transaction
  a_r8_keep_on_gnt_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_oe && !frame_n_out && gnt_n) |=> frame_oe);

  // R9: ready only while the bus pins are released
  a_r9_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!frame_oe && !irdy_oe));
endmodule

// File: tb/busmst_addr_ctrl_tb_top.sv
`timescale 1ns/1ps
module busmst_addr_ctrl_tb_top;
  localparam int AW = 32;
  localparam int CW = 4;
  localparam int NV = 8;

  // Entry: {busy edges, grant-late edges, devsel edge (0 = none), trdy extra edges, drop grant, busy on irdy}
  localparam logic [17:0] VEC [NV] = '{
    {4'd0, 4'd0, 4'd2, 4'd0, 1'b0, 1'b0},
    {4'd2, 4'd0, 4'd3, 4'd1, 1'b0, 1'b1},
    {4'd0, 4'd3, 4'd4, 4'd2, 1'b1, 1'b0},
    {4'd1, 4'd1, 4'd5, 4'd0, 1'b0, 1'b0},
    {4'd0, 4'd0, 4'd2, 4'd3, 1'b0, 1'b0},
    {4'd3, 4'd2, 4'd0, 4'd0, 1'b1, 1'b0},
    {4'd0, 4'd1, 4'd5, 4'd2, 1'b0, 1'b1},
    {4'd0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [CW-1:0] req_cmd = '0;
  logic [AW-1:0] req_addr = '0;
  logic done, claimed, aborted;
  logic gnt_n = 1'b0, devsel_n = 1'b1, trdy_n = 1'b1;
  logic ext_frame_n = 1'b1, ext_irdy_n = 1'b1;
  logic frame_n_in, irdy_n_in;
  logic frame_n_out, frame_oe, irdy_n_out, irdy_oe, ad_oe, cbe_oe;
  logic [AW-1:0] ad_out;
  logic [CW-1:0] cbe_out;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  assign frame_n_in = frame_oe ? frame_n_out : ext_frame_n;
  assign irdy_n_in  = irdy_oe  ? irdy_n_out  : ext_irdy_n;

  busmst_addr_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .done(done), .claimed(claimed),
    .aborted(aborted), .gnt_n(gnt_n), .frame_n_in(frame_n_in), .irdy_n_in(irdy_n_in),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .frame_n_out(frame_n_out), .frame_oe(frame_oe),
    .irdy_n_out(irdy_n_out), .irdy_oe(irdy_oe), .ad_out(ad_out), .ad_oe(ad_oe),
    .cbe_out(cbe_out), .cbe_oe(cbe_oe)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_vec(input int idx, input logic [17:0] v);
    int nb, ng, dv, td, q, t;
    logic drop, sel, fin;
    logic [AW-1:0] a;
    logic [CW-1:0] c;
    nb = int'(v[17:14]); ng = int'(v[13:10]); dv = int'(v[9:6]); td = int'(v[5:2]);
    drop = v[1]; sel = v[0];
    a = 32'hA000_0000 + AW'(idx * 32'h111);
    c = CW'(idx + 1);
    q = ((nb > ng) ? nb : ng) + 1;
    t = dv + td;
    req_valid = 1'b1; req_cmd = c; req_addr = a;
    chk("R9 ready before accept", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 ready low when busy", 64'(req_ready), 64'd0);
    chk("R9 status cleared on accept", 64'({claimed, aborted}), 64'd0);
    for (int k = 1; k <= q; k++) begin
      ext_frame_n = (!sel && k <= nb) ? 1'b0 : 1'b1;
      ext_irdy_n  = ( sel && k <= nb) ? 1'b0 : 1'b1;
      gnt_n       = (k <= ng) ? 1'b1 : 1'b0;
      @(negedge clk);
      if (k < q) chk("R2 no start while blocked", 64'(frame_oe), 64'd0);
      else begin
        chk("R2 frame asserted after qualifying edge", 64'({frame_oe, frame_n_out}), 64'b10);
        chk("R3 address driven", 64'({ad_oe, cbe_oe, ad_out}), {30'd0, 2'b11, a});
        chk("R3 command driven", 64'(cbe_out), 64'(c));
      end
    end
    ext_frame_n = 1'b1; ext_irdy_n = 1'b1;
    if (drop) gnt_n = 1'b1;
    @(negedge clk);
    chk("R4 irdy at clock 2", 64'({irdy_oe, irdy_n_out, frame_n_out}), 64'b100);
    chk("R3 address released", 64'({ad_oe, cbe_oe}), 64'd0);
    fin = 1'b0;
    for (int e = 2; e <= 12 && !fin; e++) begin
      devsel_n = (dv != 0 && e >= dv) ? 1'b0 : 1'b1;
      trdy_n   = (dv != 0 && e >= t)  ? 1'b0 : 1'b1;
      @(negedge clk);
      if (dv != 0) begin
        if (e < t) begin
          chk(drop ? "R8 kept after grant loss" : "R5 held while claimed",
              64'({frame_oe, frame_n_out, irdy_n_out, done}), 64'b1000);
        end else begin
          chk(td == 0 ? "R10 claim and transfer same edge" : "R7 completion pins",
              64'({frame_oe, frame_n_out, irdy_oe, irdy_n_out, done}), 64'b11111);
          chk("R5 claimed, no abort", 64'({claimed, aborted}), 64'b10);
          fin = 1'b1;
        end
      end else begin
        if (e < 5)       chk("R6 window open", 64'({frame_n_out, irdy_n_out}), 64'b00);
        else if (e == 5) chk("R6 frame released first", 64'({frame_oe, frame_n_out, irdy_n_out, done}), 64'b1100);
        else begin
          chk("R6 abort completion", 64'({irdy_n_out, done, aborted, claimed}), 64'b1110);
          fin = 1'b1;
        end
      end
    end
    devsel_n = 1'b1; trdy_n = 1'b1; gnt_n = 1'b0;
    @(negedge clk);
    chk("R7 bus released", 64'({frame_oe, irdy_oe, ad_oe, done, req_ready}), 64'b00001);
  endtask

  initial begin
    #(100000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset enables", 64'({frame_oe, irdy_oe, ad_oe, cbe_oe}), 64'd0);
    chk("R1 reset status", 64'({req_ready, done, claimed, aborted}), 64'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 64'({req_ready, frame_oe, irdy_oe}), 64'b100);
    for (int i = 0; i < NV; i++) run_vec(i, VEC[i]);
    repeat (3) @(negedge clk);
    chk("R9 abort sticky after done", 64'({aborted, done, req_ready}), 64'b101);
    run_vec(3, VEC[3]);
    repeat (2) @(negedge clk);
    chk("R9 claim sticky after done", 64'({claimed, aborted}), 64'b10);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule